// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns one 32-bit management command word into a serial frame on the MDC clock and MDIO data line of a PHY management bus. The host writes the command word into the data register, and that write starts the frame. The block then drives the word out most significant bit first, on an MDC clock divided down from the system clock. A parameter can add a 32-bit run of ones as a preamble ahead of the word.

The command word has fixed fields. Bits 31:30 hold the start pattern 01. Bits 29:28 hold the operation: 10 is a read and 01 is a write. Bits 27:23 hold the PHY address and bits 22:18 the register number. Bits 17:16 hold the turnaround pattern 10, and bits 15:0 hold the write data. For a read, the block releases MDIO during the turnaround and stays off the line while the PHY returns sixteen data bits. At the end of the frame it stores those bits in the low half of the data register.

At the end of every frame the block sets a sticky done event. The host clears the event by writing a 1 to it. The MDC half-period is a programmable speed value counted in system clocks, so one MDC period is twice that value. The speed value must be chosen so that MDC stays at or below 2.5 MHz.

Top module: `mdio_cmd_master`

## Requirements
- R1: A data-register write accepted while idle is visible in `mgmt_data` on the next cycle. After the optional preamble, the block drives bits 31 down to 0 of that word on `mdio_out` with `mdio_oe` high, one bit per MDC period.
- R2: With the preamble enabled (the default), 32 MDC periods with `mdio_out` = 1 and `mdio_oe` = 1 come before the first command bit.
- R3: MDC is low while idle. During a frame its period is 2 × `speed_val` system clocks, starting with a low half-period. A frame with the preamble ends exactly 2 × `speed_val` × 64 clocks after the write is accepted.
- R4: `mdio_out` changes only while MDC is low, so it never changes during a high half-period. `mdio_in` is sampled on the rising edge of MDC.
- R5: For a read (bits 29:28 = 10), `mdio_oe` drops at the second turnaround bit (frame bit 16) and stays low through data bit 0. For a write (bits 29:28 = 01), `mdio_oe` stays high for the whole frame. `mdio_oe` is low while idle.
- R6: When a read frame ends, `mgmt_data[15:0]` takes the 16 bits sampled during the data phase, first bit as bit 15, and bits 31:16 keep the command. After a write frame, `mgmt_data` still holds the written word.
- R7: `done_evt` is set on the cycle after the last MDC falling edge of a frame and stays set until `ack_wr` is pulsed with `ack_bit` = 1. A pulse with `ack_bit` = 0 has no effect. A frame end in the same cycle as a clear leaves the event set.
- R8: While `speed_val` = 0, MDC does not toggle and a data-register write is ignored: `mgmt_data` is unchanged and no event is raised.
- R9: A data-register write during a frame is ignored. `mgmt_data` and the serial frame in progress are unchanged.
- R10: After reset, `mdc`, `mdio_oe`, `mgmt_data` and `done_evt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_val | input | SPD_W | MDC half-period in system clocks; 0 stops the bus |
| cmd_wr | input | 1 | Write strobe for the data register |
| cmd_wdata | input | 32 | Command word to write |
| ack_wr | input | 1 | Write strobe for the event register |
| ack_bit | input | 1 | Value written to the event bit; 1 clears the event |
| mdio_in | input | 1 | MDIO line level seen from the pad |
| mgmt_data | output | 32 | Data register: the command word, with read data in bits 15:0 after a read |
| done_evt | output | 1 | Sticky frame-done event |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A bit counter off by one shows up at the ports on the first faulty frame. The frame either ends at a cycle other than 2 × speed × 64 clocks, or the sampled MDIO stream is shifted against the expected word, and the read data comes back rotated. A wrong output-enable window shows up within one MDC period of the second turnaround bit. A wrong divider shows up as a wrong spacing between the first two MDC rising edges. Faults in the event logic or the busy guard show up on the very next clear pulse or intruding write, because both are checked one cycle later.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the MDIO management frame master.
// Assumes the fixed 32-bit command layout: start 31:30, op 29:28,
// PHY address 27:23, register 22:18, turnaround 17:16, data 15:0.
package mdio_pkg;
    localparam int FRAME_BITS   = 32;
    localparam int PRE_BITS     = 32;
    localparam int RD_BITS      = 16;
    localparam int OP_HI        = 29;
    localparam int OP_LO        = 28;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    // Frame position (0 = bit 31) of the second turnaround bit.
    localparam int TA_RELEASE_POS = 15;
    // Frame position of the first read data bit.
    localparam int DATA_FIRST_POS = 16;

    // True when the command word encodes a read.
    function automatic logic word_is_read(input logic [FRAME_BITS-1:0] w);
        return w[OP_HI:OP_LO] == OP_READ;
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
// Module: MDC generator. While run is high, it toggles mdc every speed
// system clocks and flags each rising and falling edge one cycle early
// (rise/fall are high in the cycle before mdc changes).
// Assumes speed is stable while run is high. A speed of 0 never ticks.
module mdio_clk_div #(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [SPD_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    // Half-period boundary: the counter has reached speed-1.
    assign tick = run && (speed != '0) && (cnt_q == speed - SPD_W'(1));
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    // Count system clocks and toggle MDC at each half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + SPD_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
// Module: frame sequencer. It latches a command word on start and steps one
// bit per MDC period. The drive value and enable change on MDC falling
// edges, and read data is sampled on MDC rising edges. fin pulses in the
// cycle before the final falling edge.
// Assumes start is asserted only while idle. Preamble bits come first when enabled.
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter bit PREAMBLE_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] cmd_word,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_in,
    output logic                  busy,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    output logic                  fin,
    output logic                  rd_fin,
    output logic [RD_BITS-1:0]    rd_data
);
    localparam int PRE_LEN = PREAMBLE_EN ? PRE_BITS : 0;
    localparam int TOTAL   = PRE_LEN + FRAME_BITS;
    localparam int IDX_W   = $clog2(TOTAL + 1);
    localparam int POS_W   = $clog2(FRAME_BITS);

    logic                  busy_q;
    logic [IDX_W-1:0]      idx_q;
    logic [IDX_W-1:0]      idx_nxt;
    logic [FRAME_BITS-1:0] cmd_q;
    logic                  is_rd_q;
    logic                  drv_q;
    logic                  oe_q;
    logic [RD_BITS-1:0]    cap_q;
    logic                  pre_cur;
    logic                  pre_nxt;
    logic [POS_W-1:0]      pos_cur;
    logic [POS_W-1:0]      pos_nxt;
    logic                  last_bit;
    logic                  first_bit;
    logic                  nxt_bit;
    logic                  nxt_oe;

    assign idx_nxt = idx_q + IDX_W'(1);

    // Map the bit index to preamble or frame position, depending on the variant.
    generate
        if (PRE_LEN > 0) begin : g_pre
            assign pre_cur   = idx_q   < IDX_W'(PRE_LEN);
            assign pre_nxt   = idx_nxt < IDX_W'(PRE_LEN);
            assign pos_cur   = POS_W'(idx_q   - IDX_W'(PRE_LEN));
            assign pos_nxt   = POS_W'(idx_nxt - IDX_W'(PRE_LEN));
            assign first_bit = 1'b1;
        end else begin : g_nopre
            assign pre_cur   = 1'b0;
            assign pre_nxt   = 1'b0;
            assign pos_cur   = POS_W'(idx_q);
            assign pos_nxt   = POS_W'(idx_nxt);
            assign first_bit = cmd_word[FRAME_BITS-1];
        end
    endgenerate

    assign last_bit = idx_q == IDX_W'(TOTAL - 1);
    assign fin      = busy_q && fall && last_bit;
    assign rd_fin   = fin && is_rd_q;

    // Next drive bit and enable, applied at the coming MDC falling edge.
    always_comb begin
        nxt_bit = pre_nxt ? 1'b1 : cmd_q[POS_W'(FRAME_BITS - 1) - pos_nxt];
        nxt_oe  = !(is_rd_q && !pre_nxt && (pos_nxt >= POS_W'(TA_RELEASE_POS)));
    end

    // Frame control: latch the command, advance on falling edges, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            cmd_q   <= '0;
            is_rd_q <= 1'b0;
            drv_q   <= 1'b1;
            oe_q    <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            cmd_q   <= cmd_word;
            is_rd_q <= word_is_read(cmd_word);
            drv_q   <= first_bit;
            oe_q    <= 1'b1;
        end else if (busy_q && fall) begin
            if (last_bit) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
                drv_q  <= 1'b1;
                oe_q   <= 1'b0;
            end else begin
                idx_q  <= idx_nxt;
                drv_q  <= nxt_bit;
                oe_q   <= nxt_oe;
            end
        end
    end

    // Read capture: shift in mdio_in on rising edges in the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (start && !busy_q) begin
            cap_q <= '0;
        end else if (busy_q && rise && is_rd_q && !pre_cur &&
                     (pos_cur >= POS_W'(DATA_FIRST_POS))) begin
            cap_q <= {cap_q[RD_BITS-2:0], mdio_in};
        end
    end

    assign busy     = busy_q;
    assign mdio_out = drv_q;
    assign mdio_oe  = oe_q;
    assign rd_data  = cap_q;
endmodule

// File: rtl/mdio_cmd_master.sv
`timescale 1ns/1ps
// Module: MDIO management frame master (top). It holds the data register
// and the sticky done event, and starts a frame on an accepted
// data-register write.
// Assumes speed_val stays constant during a frame. Writes during a frame,
// or while speed_val is 0, are dropped.
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int SPD_W       = 8,
    parameter bit PREAMBLE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed_val,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_wdata,
    input  logic             ack_wr,
    input  logic             ack_bit,
    input  logic             mdio_in,
    output logic [31:0]      mgmt_data,
    output logic             done_evt,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe
);
    logic               busy;
    logic               accept;
    logic               rise;
    logic               fall;
    logic               fin;
    logic               rd_fin;
    logic [RD_BITS-1:0] rd_data;
    logic [31:0]        data_q;
    logic               evt_q;

    assign accept = cmd_wr && !busy && (speed_val != '0);

    mdio_clk_div #(.SPD_W(SPD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .speed (speed_val),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_frame_seq #(.PREAMBLE_EN(PREAMBLE_EN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .cmd_word (cmd_wdata),
        .rise     (rise),
        .fall     (fall),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .fin      (fin),
        .rd_fin   (rd_fin),
        .rd_data  (rd_data)
    );

    // Data register: load on an accepted write, take read data at the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= cmd_wdata;
        end else if (rd_fin) begin
            data_q[RD_BITS-1:0] <= rd_data;
        end
    end

    // Done event: set at the end of a frame (set wins), cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (fin) begin
            evt_q <= 1'b1;
        end else if (ack_wr && ack_bit) begin
            evt_q <= 1'b0;
        end
    end

    assign mgmt_data = data_q;
    assign done_evt  = evt_q;
endmodule

// Checker: temporal properties of the MDIO master, attached by bind.
module mdio_cmd_master_chk #(
    parameter int SPD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             fin,
    input logic             rise,
    input logic             fall,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             cmd_wr,
    input logic [SPD_W-1:0] speed_val,
    input logic [31:0]      mgmt_data,
    input logic             done_evt,
    input logic             ack_wr,
    input logic             ack_bit
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R3
    AST_EDGE_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall})); // R3
    AST_MDIO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out)); // R4
    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R5
    AST_EVT_SET_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_evt); // R7
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !(ack_wr && ack_bit)) |=> done_evt); // R7
    AST_SPEED0_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((speed_val == '0) && !busy) |=> !busy); // R8
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin && cmd_wr) |=> $stable(mgmt_data)); // R9
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.SPD_W(SPD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .fin       (fin),
    .rise      (rise),
    .fall      (fall),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .cmd_wr    (cmd_wr),
    .speed_val (speed_val),
    .mgmt_data (mgmt_data),
    .done_evt  (done_evt),
    .ack_wr    (ack_wr),
    .ack_bit   (ack_bit)
);

// File: tb/mdio_cmd_master_test.sv
`timescale 1ns/1ps
// Bench: sweeps all PHY addresses and register numbers and several speeds.
// Each frame's serial stream, timing, read data and event are checked
// against values computed from the command word.
module mdio_cmd_master_test;
    localparam int SPD_W = 8;
    localparam int PRE   = 32;
    localparam int TOT   = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SPD_W-1:0] speed_val = '0;
    logic             cmd_wr = 1'b0;
    logic [31:0]      cmd_wdata = '0;
    logic             ack_wr = 1'b0;
    logic             ack_bit = 1'b0;
    logic             mdio_in = 1'b1;
    logic [31:0]      mgmt_data;
    logic             done_evt;
    logic             mdc;
    logic             mdio_out;
    logic             mdio_oe;

    always #10 clk = ~clk;

    mdio_cmd_master #(.SPD_W(SPD_W), .PREAMBLE_EN(1'b1)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_val (speed_val),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .ack_wr    (ack_wr),
        .ack_bit   (ack_bit),
        .mdio_in   (mdio_in),
        .mgmt_data (mgmt_data),
        .done_evt  (done_evt),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    int          n_run = 0;
    int          n_fail = 0;
    logic        obs_d  [TOT];
    logic        obs_oe [TOT];
    longint      t_rise [TOT];
    int          rise_n = 0;
    int          fall_n = 0;
    logic [15:0] phy_rd = '0;

    // Record the line state at every MDC rising edge.
    always @(posedge mdc) begin
        if (rise_n < TOT) begin
            obs_d[rise_n]  = mdio_out;
            obs_oe[rise_n] = mdio_oe;
            t_rise[rise_n] = $time;
        end
        rise_n++;
    end

    // PHY model: present the next read data bit after each MDC falling edge.
    always @(negedge mdc) begin
        int p;
        fall_n++;
        p = fall_n - PRE;
        if (p >= 16 && p <= 31) mdio_in = phy_rd[31-p];
        else                    mdio_in = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_rd(input int a, input int r);
        return 32'h6002_0000 | (32'(a & 31) << 23) | (32'(r & 31) << 18);
    endfunction

    function automatic logic [31:0] mk_wr(input int a, input int r, input logic [15:0] d);
        return 32'h5002_0000 | (32'(a & 31) << 23) | (32'(r & 31) << 18) | 32'(d);
    endfunction

    // Run one frame and check its timing, stream, data register and event.
    task automatic run_frame(input logic [31:0] word, input int s, input logic [15:0] pv,
                             input int intrude_at, input bit hold_clear);
        bit  rd;
        int  n_exp;
        int  cnt;
        int  bad_pre;
        int  bad_d;
        int  bad_oe;
        int  bad_t;
        logic [31:0] exp_data;
        rd = (word[29:28] == 2'b10);
        @(negedge clk);
        speed_val = SPD_W'(s);
        phy_rd    = pv;
        rise_n    = 0;
        fall_n    = 0;
        ack_wr    = hold_clear;
        ack_bit   = hold_clear;
        cmd_wr    = 1'b1;
        cmd_wdata = word;
        @(negedge clk);
        cmd_wr = 1'b0;
        cnt    = 1;
        n_exp  = 2 * s * TOT + 1;
        chk(mgmt_data == word, "R1", "data register after write", mgmt_data, word);
        while (!done_evt && cnt < n_exp + 20) begin
            if (cnt == intrude_at) begin
                cmd_wr    = 1'b1;
                cmd_wdata = ~word;
            end
            @(negedge clk);
            cnt++;
            if (cmd_wr) begin
                cmd_wr = 1'b0;
                chk(mgmt_data == word, "R9", "write during frame dropped", mgmt_data, word);
            end
        end
        chk(cnt == n_exp, "R3", "frame length in clocks", cnt, n_exp);
        chk(done_evt == 1'b1, "R7", "event set at frame end", done_evt, 1);
        if (hold_clear) begin
            @(negedge clk);
            chk(done_evt == 1'b0, "R7", "held clear acts after set", done_evt, 0);
            ack_wr  = 1'b0;
            ack_bit = 1'b0;
        end else begin
            repeat (3) @(negedge clk);
            chk(done_evt == 1'b1, "R7", "event sticky", done_evt, 1);
            ack_wr = 1'b1; ack_bit = 1'b0;
            @(negedge clk);
            ack_wr = 1'b0;
            chk(done_evt == 1'b1, "R7", "write 0 leaves event", done_evt, 1);
            ack_wr = 1'b1; ack_bit = 1'b1;
            @(negedge clk);
            ack_wr = 1'b0; ack_bit = 1'b0;
            chk(done_evt == 1'b0, "R7", "write 1 clears event", done_evt, 0);
        end
        exp_data = rd ? {word[31:16], pv} : word;
        if (rd)
            chk(mgmt_data[15:0] == pv, "R4", "read data sampled on rise",
                mgmt_data[15:0], pv);
        chk(mgmt_data == exp_data, "R6", "data register after frame", mgmt_data, exp_data);
        chk(rise_n == TOT, "R3", "MDC rising edges per frame", rise_n, TOT);
        bad_pre = 0; bad_d = 0; bad_oe = 0; bad_t = 0;
        for (int i = 0; i < TOT; i++) begin
            if (i < PRE) begin
                if (obs_d[i] !== 1'b1 || obs_oe[i] !== 1'b1) bad_pre++;
            end else begin
                int  p;
                bit  eo;
                p  = i - PRE;
                eo = !(rd && p >= 15);
                if (obs_oe[i] !== eo) bad_oe++;
                if (eo && obs_d[i] !== word[31-p]) bad_d++;
            end
            if (i > 0 && (t_rise[i] - t_rise[i-1]) != longint'(40 * s)) bad_t++;
        end
        chk(bad_pre == 0, "R2", "preamble bits", bad_pre, 0);
        chk(bad_d == 0, "R1", "serial command bits", bad_d, 0);
        chk(bad_oe == 0, "R5", "output enable window", bad_oe, 0);
        chk(bad_t == 0, "R3", "MDC period", bad_t, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R5", "idle line after frame",
            {mdc, mdio_oe}, 0);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        // R10: reset state.
        chk(mdc == 1'b0, "R10", "mdc in reset", mdc, 0);
        chk(mdio_oe == 1'b0, "R10", "oe in reset", mdio_oe, 0);
        chk(mgmt_data == 32'd0, "R10", "data in reset", mgmt_data, 0);
        chk(done_evt == 1'b0, "R10", "event in reset", done_evt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every PHY address with reads at speed 1.
        for (int a = 0; a < 32; a++)
            run_frame(mk_rd(a, 31 - a), 1, 16'(16'hA5C3 ^ (a * 16'h0913)), -1, 1'b0);
        // Sweep every register number with writes at speeds 1..3.
        for (int r = 0; r < 32; r++)
            run_frame(mk_wr(31 - r, r, 16'(16'h3C5A + r * 16'h0101)), 1 + (r % 3),
                      16'h0, -1, 1'b0);
        // Slower dividers, both directions.
        run_frame(mk_rd(5, 1), 5, 16'h8001, -1, 1'b0);
        run_frame(mk_wr(17, 4, 16'hFFFF), 7, 16'h0, -1, 1'b0);
        run_frame(mk_rd(31, 31), 4, 16'h0000, -1, 1'b0);
        // R9: intruding writes at several points of a frame.
        run_frame(mk_rd(9, 2), 2, 16'h1234, 37, 1'b0);
        run_frame(mk_wr(3, 8, 16'hBEEF), 2, 16'h0, 200, 1'b0);
        // R7: clear held through the frame end, set wins.
        run_frame(mk_rd(12, 6), 1, 16'h6A6A, -1, 1'b1);

        // R8: speed 0 blocks a write.
        held = mgmt_data;
        @(negedge clk);
        speed_val = '0;
        rise_n    = 0;
        cmd_wr    = 1'b1;
        cmd_wdata = mk_wr(1, 1, 16'h5555);
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (60) @(negedge clk);
        chk(rise_n == 0, "R8", "no MDC at speed 0", rise_n, 0);
        chk(mgmt_data == held, "R8", "write ignored at speed 0", mgmt_data, held);
        chk(done_evt == 1'b0, "R8", "no event at speed 0", done_evt, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule